// File: doc/BRIEF.md
# Sector Load-and-Program Write Controller

This block models how one flash segment accepts a sector write, in a single synchronous clock domain. The host presents a combined write strobe: it is high while both the card enable and the write enable are asserted. Along with the strobe it presents an address and data. Each qualified strobe pulse loads one byte, or one 16-bit word, into a 256-byte page buffer. The byte address is taken when the strobe goes active. The data is taken in the last cycle before the strobe drops.

Loading continues for as long as each new strobe arrives within a programmable window of idle cycles. When the window expires, the block enters a self-timed programming period of fixed length. At the end of that period the whole sector is committed to the behavioural array in one step. Bytes that were loaded take their new values. Bytes that were not loaded take a fixed marker value, which stands in for undefined contents. No erase step is needed: any sector can be rewritten at any time.

A read port shows the array contents. A busy output covers the programming period. A one-cycle error pulse reports a load that targets a sector other than the one the window opened on.

Top module: `sector_write_ctrl`

## Requirements
- R1: After reset, `busy` and `load_err` are low, and every array byte reads ERASED_VAL (8'hFF by default).
- R2: The address of a load is taken in the first cycle `wr_strobe` is sampled high. The data and `wide` are taken in the last cycle it is sampled high. Changes in between have no effect.
- R3: The upper `addr` bits [SEC_W+7:8] select the sector and `addr[7:0]` selects the byte within it. In byte mode (`wide`=0), `wdata[7:0]` is loaded.
- R4: When programming completes, the sector reads back each loaded byte's last loaded value, and FILL_VAL (8'h5A by default) in every byte not loaded in that window. The array does not change before completion.
- R5: The first accepted load opens the window. The idle counter clears on each accepted load. It advances only in cycles where `wr_strobe` is low both now and in the previous cycle. Programming starts when the counter reaches LOAD_WIN.
- R6: `busy` is high for exactly PROG_CYC cycles, starting the cycle after the window closes. Loads that complete during those cycles are ignored.
- R7: While a window is open, a load whose sector differs from the window's sector is dropped. It raises `load_err` for one cycle and does not clear the idle counter.
- R8: A strobe pulse sampled high for fewer than MIN_PULSE cycles loads nothing and does not open a window.
- R9: With `wide`=1, `addr[0]` is ignored. `wdata[7:0]` goes to the even byte and `wdata[15:8]` to the odd byte of the addressed pair, both in the same load.
- R10: Programming an already written sector replaces all 256 of its bytes without any erase.
- R11: Programming one sector leaves every other sector unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_strobe | input | 1 | Combined enable-and-write strobe, high while active |
| wide | input | 1 | 1 = 16-bit word load, 0 = byte load |
| addr | input | SEC_W+8 | Load address: sector in upper bits, byte in [7:0] |
| wdata | input | 16 | Load data |
| rd_addr | input | SEC_W+8 | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr` |
| busy | output | 1 | High during the programming period |
| load_err | output | 1 | One-cycle pulse on a dropped wrong-sector load |

## Verification
The bench builds the block with four sectors, a load window of 6 idle cycles, a 12-cycle programming period and a minimum pulse of 2 cycles. The real timeouts would take tens of thousands to over a million cycles. With these short values, window expiry, loads that arrive during programming, glitch rejection and repeated rewrites of the same sector all fall within a short run. A sweeping read address lets every cycle's comparison against the bench model cover the whole array.

// File: rtl/secwr_pkg.sv
package secwr_pkg;

    localparam int PAGE_AW    = 8;
    localparam int PAGE_BYTES = 1 << PAGE_AW;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_PROG = 2'd2
    } wr_state_e;

    typedef struct packed {
        logic                 valid;
        logic                 wide;
        logic [PAGE_AW-1:0]   idx;
        logic [15:0]          data;
    } load_ev_t;

    // Index of one byte of the even/odd pair holding idx
    function automatic logic [PAGE_AW-1:0] pair_idx(input logic [PAGE_AW-1:0] idx,
                                                    input logic hi);
        return {idx[PAGE_AW-1:1], hi};
    endfunction

endpackage

// File: rtl/secwr_strobe_filter.sv
module secwr_strobe_filter
    import secwr_pkg::*;
#(
    parameter int SEC_W     = 2,
    parameter int MIN_PULSE = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    strobe,
    input  logic                    wide,
    input  logic [SEC_W+PAGE_AW-1:0] addr,
    input  logic [15:0]             wdata,
    output load_ev_t                ev,
    output logic [SEC_W-1:0]        ev_sector,
    output logic                    hold
);
    localparam int                WW   = $clog2(MIN_PULSE + 1);
    localparam logic [WW-1:0]     MINW = WW'(MIN_PULSE);

    logic                       s_q;
    logic [WW-1:0]              width_q;
    logic [SEC_W+PAGE_AW-1:0]   cap_addr;
    logic [15:0]                cap_data;
    logic                       cap_wide;

    assign hold = strobe | s_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q       <= 1'b0;
            width_q   <= '0;
            cap_addr  <= '0;
            cap_data  <= '0;
            cap_wide  <= 1'b0;
            ev        <= '0;
            ev_sector <= '0;
        end else begin
            s_q      <= strobe;
            ev.valid <= 1'b0;
            if (strobe && !s_q) begin
                cap_addr <= addr;
                width_q  <= WW'(1);
            end else if (strobe && width_q < MINW) begin
                width_q <= width_q + 1'b1;
            end
            if (strobe) begin
                cap_data <= wdata;
                cap_wide <= wide;
            end
            if (!strobe && s_q && width_q >= MINW) begin
                ev.valid  <= 1'b1;
                ev.wide   <= cap_wide;
                ev.idx    <= cap_addr[PAGE_AW-1:0];
                ev.data   <= cap_data;
                ev_sector <= cap_addr[SEC_W+PAGE_AW-1:PAGE_AW];
            end
        end
    end

    AST_GLITCH_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (!strobe && s_q && width_q < MINW) |=> !ev.valid); // R8

    AST_EV_NEEDS_FALL: assert property (@(posedge clk) disable iff (rst)
        ev.valid |-> ($past(s_q) && !$past(strobe))); // R2

endmodule

// File: rtl/secwr_seq.sv
module secwr_seq
    import secwr_pkg::*;
#(
    parameter int SEC_W    = 2,
    parameter int LOAD_WIN = 18750,
    parameter int PROG_CYC = 1250000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_valid,
    input  logic [SEC_W-1:0]  ev_sector,
    input  logic              hold,
    output logic              buf_we,
    output logic              commit,
    output logic [SEC_W-1:0]  commit_sec,
    output logic              busy,
    output logic              load_err
);
    localparam int            TW        = $clog2(LOAD_WIN + 1);
    localparam int            PW        = $clog2(PROG_CYC + 1);
    localparam logic [TW-1:0] WIN_LAST  = TW'(LOAD_WIN - 1);
    localparam logic [PW-1:0] PROG_LAST = PW'(PROG_CYC - 1);

    wr_state_e         state_q;
    logic [TW-1:0]     timer_q;
    logic [PW-1:0]     pcnt_q;
    logic [SEC_W-1:0]  sec_q;
    logic              reject;

    always_comb begin
        buf_we = ev_valid && ((state_q == ST_IDLE) ||
                              (state_q == ST_LOAD && ev_sector == sec_q));
        reject = ev_valid && state_q == ST_LOAD && ev_sector != sec_q;
        commit = (state_q == ST_PROG) && (pcnt_q == PROG_LAST);
    end

    assign commit_sec = sec_q;
    assign busy       = (state_q == ST_PROG);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            timer_q  <= '0;
            pcnt_q   <= '0;
            sec_q    <= '0;
            load_err <= 1'b0;
        end else begin
            load_err <= reject;
            unique case (state_q)
                ST_IDLE: begin
                    if (buf_we) begin
                        sec_q   <= ev_sector;
                        timer_q <= '0;
                        state_q <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (buf_we) begin
                        timer_q <= '0;
                    end else if (!hold) begin
                        if (timer_q == WIN_LAST) begin
                            state_q <= ST_PROG;
                            pcnt_q  <= '0;
                        end else begin
                            timer_q <= timer_q + 1'b1;
                        end
                    end
                end
                ST_PROG: begin
                    if (commit) state_q <= ST_IDLE;
                    else        pcnt_q  <= pcnt_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    AST_PROG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PROG && pcnt_q != PROG_LAST) |=> busy); // R6

    AST_PROG_ENDS: assert property (@(posedge clk) disable iff (rst)
        commit |=> !busy); // R6

    AST_PROG_ENTRY: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(state_q == ST_LOAD && !hold)); // R5

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        load_err |=> !load_err); // R7

    AST_ERR_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        load_err |-> $past(state_q == ST_LOAD)); // R7

endmodule

// File: rtl/secwr_store.sv
module secwr_store
    import secwr_pkg::*;
#(
    parameter int         SEC_W      = 2,
    parameter logic [7:0] ERASED_VAL = 8'hFF,
    parameter logic [7:0] FILL_VAL   = 8'h5A
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     we,
    input  load_ev_t                 ev,
    input  logic                     commit,
    input  logic [SEC_W-1:0]         commit_sec,
    input  logic [SEC_W+PAGE_AW-1:0] rd_addr,
    output logic [7:0]               rd_data
);
    localparam int SECTORS = 1 << SEC_W;

    logic [7:0]            page_d [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] page_v;
    logic [7:0]            mem_q  [SECTORS][PAGE_BYTES];

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_entry
        localparam logic [PAGE_AW-1:0] GI = PAGE_AW'(g);
        logic       hit;
        logic [7:0] byte_q;
        logic       vld_q;

        assign hit = we && (ev.wide ? (pair_idx(ev.idx, GI[0]) == GI)
                                    : (ev.idx == GI));

        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q <= '0;
                vld_q  <= 1'b0;
            end else if (hit) begin
                byte_q <= (ev.wide && GI[0]) ? ev.data[15:8] : ev.data[7:0];
                vld_q  <= 1'b1;
            end else if (commit) begin
                vld_q  <= 1'b0;
            end
        end

        assign page_d[g] = byte_q;
        assign page_v[g] = vld_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SECTORS; s++)
                for (int i = 0; i < PAGE_BYTES; i++)
                    mem_q[s][i] <= ERASED_VAL;
        end else if (commit) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                mem_q[commit_sec][i] <= page_v[i] ? page_d[i] : FILL_VAL;
        end
    end

    assign rd_data = mem_q[rd_addr[SEC_W+PAGE_AW-1:PAGE_AW]][rd_addr[PAGE_AW-1:0]];

    AST_PAGE_CLEARED: assert property (@(posedge clk) disable iff (rst)
        commit |=> (page_v == '0)); // R4

    AST_NO_LOAD_AT_COMMIT: assert property (@(posedge clk) disable iff (rst)
        !(we && commit)); // R6

endmodule

// File: rtl/sector_write_ctrl.sv
module sector_write_ctrl
    import secwr_pkg::*;
#(
    parameter int         SEC_W      = 2,
    parameter int         LOAD_WIN   = 18750,
    parameter int         PROG_CYC   = 1250000,
    parameter int         MIN_PULSE  = 2,
    parameter logic [7:0] ERASED_VAL = 8'hFF,
    parameter logic [7:0] FILL_VAL   = 8'h5A
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_strobe,
    input  logic                 wide,
    input  logic [SEC_W+7:0]     addr,
    input  logic [15:0]          wdata,
    input  logic [SEC_W+7:0]     rd_addr,
    output logic [7:0]           rd_data,
    output logic                 busy,
    output logic                 load_err
);
    load_ev_t          ev;
    logic [SEC_W-1:0]  ev_sector;
    logic              hold;
    logic              buf_we;
    logic              commit;
    logic [SEC_W-1:0]  commit_sec;

    secwr_strobe_filter #(
        .SEC_W     (SEC_W),
        .MIN_PULSE (MIN_PULSE)
    ) u_filter (
        .clk       (clk),
        .rst       (rst),
        .strobe    (wr_strobe),
        .wide      (wide),
        .addr      (addr),
        .wdata     (wdata),
        .ev        (ev),
        .ev_sector (ev_sector),
        .hold      (hold)
    );

    secwr_seq #(
        .SEC_W    (SEC_W),
        .LOAD_WIN (LOAD_WIN),
        .PROG_CYC (PROG_CYC)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .ev_valid   (ev.valid),
        .ev_sector  (ev_sector),
        .hold       (hold),
        .buf_we     (buf_we),
        .commit     (commit),
        .commit_sec (commit_sec),
        .busy       (busy),
        .load_err   (load_err)
    );

    secwr_store #(
        .SEC_W      (SEC_W),
        .ERASED_VAL (ERASED_VAL),
        .FILL_VAL   (FILL_VAL)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .we         (buf_we),
        .ev         (ev),
        .commit     (commit),
        .commit_sec (commit_sec),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data)
    );

    AST_BUSY_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        $past(busy) |-> !load_err); // R6

endmodule

// File: tb/tb_sector_write_ctrl.sv
module tb_sector_write_ctrl;
    localparam int         SW   = 2;
    localparam int         WIN  = 6;
    localparam int         PC   = 12;
    localparam int         MP   = 2;
    localparam logic [7:0] ER   = 8'hFF;
    localparam logic [7:0] FILL = 8'h5A;
    localparam int         NB   = (1 << SW) * 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_strobe = 1'b0;
    logic        wide = 1'b0;
    logic [9:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [9:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        busy;
    logic        load_err;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    bit sweep_en = 1'b1;
    int peek_addr = 0;
    int err_seen = 0;
    bit busy_seen = 1'b0;

    always #4 clk = ~clk;

    sector_write_ctrl #(
        .SEC_W (SW), .LOAD_WIN (WIN), .PROG_CYC (PC), .MIN_PULSE (MP),
        .ERASED_VAL (ER), .FILL_VAL (FILL)
    ) dut (
        .clk (clk), .rst (rst), .wr_strobe (wr_strobe), .wide (wide),
        .addr (addr), .wdata (wdata), .rd_addr (rd_addr), .rd_data (rd_data),
        .busy (busy), .load_err (load_err)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int mem [NB];
    int pbuf [256];
    int m_state, m_timer, m_pcnt, m_sec, m_width;
    int c_addr, c_data, ev_a, ev_d;
    bit c_wide, ev_v, ev_w, m_prev, m_err;

    always @(negedge clk) rd_addr <= sweep_en ? rd_addr + 10'd7 : peek_addr[9:0];

    always @(posedge clk) begin
        bit hold, acc, rej, nv;
        if (rst) begin
            foreach (mem[i]) mem[i] = ER;
            foreach (pbuf[i]) pbuf[i] = -1;
            m_state = 0; m_timer = 0; m_pcnt = 0; m_sec = 0; m_width = 0;
            m_prev = 0; m_err = 0; ev_v = 0; c_addr = 0; c_data = 0; c_wide = 0;
        end else begin
            hold = wr_strobe || m_prev;
            acc = ev_v && (m_state == 0 || (m_state == 1 && (ev_a >> 8) == m_sec));
            rej = ev_v && m_state == 1 && (ev_a >> 8) != m_sec;
            m_err = rej;
            if (acc) begin
                if (ev_w) begin
                    pbuf[(ev_a & 255) & ~1] = ev_d & 255;
                    pbuf[(ev_a & 255) | 1]  = (ev_d >> 8) & 255;
                end else begin
                    pbuf[ev_a & 255] = ev_d & 255;
                end
            end
            if (m_state == 0) begin
                if (acc) begin m_sec = ev_a >> 8; m_timer = 0; m_state = 1; end
            end else if (m_state == 1) begin
                if (acc) m_timer = 0;
                else if (!hold) begin
                    m_timer++;
                    if (m_timer == WIN) begin m_state = 2; m_pcnt = 0; end
                end
            end else begin
                m_pcnt++;
                if (m_pcnt == PC) begin
                    for (int i = 0; i < 256; i++)
                        mem[m_sec*256 + i] = (pbuf[i] >= 0) ? pbuf[i] : FILL;
                    foreach (pbuf[i]) pbuf[i] = -1;
                    m_state = 0;
                end
            end
            nv = !wr_strobe && m_prev && m_width >= MP;
            if (nv) begin ev_a = c_addr; ev_d = c_data; ev_w = c_wide; end
            ev_v = nv;
            if (wr_strobe && !m_prev) begin c_addr = addr; m_width = 1; end
            else if (wr_strobe) m_width++;
            if (wr_strobe) begin c_data = wdata; c_wide = wide; end
            m_prev = wr_strobe;
        end
        #2;
        if (!rst && !finished) begin
            check("R6 busy", busy, (m_state == 2));
            check("R7 load_err", load_err, m_err);
            check("R4 rd_data", rd_data, mem[rd_addr]);
            if (load_err) err_seen++;
            if (busy) busy_seen = 1'b1;
        end
    end

    task automatic pulse(input int a, input int d, input bit w, input int hi, input int gap);
        @(negedge clk);
        addr = a[9:0]; wdata = d[15:0]; wide = w; wr_strobe = 1'b1;
        repeat (hi) @(negedge clk);
        wr_strobe = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic peek(input string tag, input int a, input int exp);
        sweep_en = 1'b0;
        peek_addr = a;
        @(negedge clk);
        @(negedge clk);
        #1 check(tag, rd_data, exp);
        sweep_en = 1'b1;
    endtask

    task automatic settle();
        repeat (WIN + PC + 8) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 busy after reset", busy, 0);
        check("R1 load_err after reset", load_err, 0);
        peek("R1 erased byte", 10'h000, ER);
        peek("R1 erased byte", 10'h3FF, ER);

        // R3 byte loads into sector 1, R11 sector 0 untouched
        for (int i = 0; i < 10; i++) pulse(256 + i, 16'h10 + i, 1'b0, 3, 2);
        settle();
        peek("R3 loaded byte", 256 + 0, 8'h10);
        peek("R3 loaded byte", 256 + 9, 8'h19);
        peek("R4 unloaded byte fill", 256 + 20, FILL);
        peek("R11 other sector", 0, ER);

        // R8 narrow pulse ignored
        busy_seen = 1'b0;
        pulse(512 + 3, 16'h00C3, 1'b0, 1, 2);
        settle();
        check("R8 no program after glitch", busy_seen, 0);
        peek("R8 glitch byte unchanged", 512 + 3, ER);

        // R7 wrong-sector load dropped
        err_seen = 0;
        pulse(5, 16'h0077, 1'b0, 3, 1);
        pulse(768 + 5, 16'h0099, 1'b0, 3, 1);
        settle();
        check("R7 error pulses", err_seen, 1);
        peek("R7 dropped byte", 768 + 5, ER);
        peek("R7 window byte", 5, 8'h77);
        peek("R4 fill in window sector", 6, FILL);

        // R5/R6 gap longer than window; second load falls in programming
        pulse(256 + 100, 16'h00AB, 1'b0, 3, WIN + 3);
        pulse(256 + 101, 16'h00CD, 1'b0, 3, 0);
        settle();
        peek("R5 loaded before gap", 256 + 100, 8'hAB);
        peek("R6 load during busy ignored", 256 + 101, FILL);
        peek("R10 rewrite replaces old byte", 256 + 0, FILL);

        // R9 word mode, addr[0] ignored
        pulse(512 + 0, 16'hB1A1, 1'b1, 3, 2);
        pulse(512 + 3, 16'hD2C2, 1'b1, 3, 2);
        settle();
        peek("R9 even byte", 512 + 0, 8'hA1);
        peek("R9 odd byte", 512 + 1, 8'hB1);
        peek("R9 even byte addr0 set", 512 + 2, 8'hC2);
        peek("R9 odd byte addr0 set", 512 + 3, 8'hD2);

        // R2 address at start, data at end of pulse
        @(negedge clk);
        addr = 10'(768 + 7); wdata = 16'h0033; wide = 1'b0; wr_strobe = 1'b1;
        @(negedge clk);
        addr = 10'(768 + 8); wdata = 16'h0044;
        @(negedge clk);
        wr_strobe = 1'b0;
        settle();
        peek("R2 data from last cycle", 768 + 7, 8'h44);
        peek("R2 late address ignored", 768 + 8, FILL);

        // R10 rewrite of sector 0 with two loads
        pulse(5, 16'h0011, 1'b0, 2, 1);
        pulse(5, 16'h0022, 1'b0, 2, 1);
        settle();
        peek("R10 last load wins", 5, 8'h22);
        peek("R11 sector 2 intact", 512 + 1, 8'hB1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule